// File: doc/BRIEF.md
# Banked Pin Controller with Edge Interrupts

This block gives software control over 32 general-purpose pins through a small 32-bit register bus. Software chooses a direction for each pin and drives a level onto each output pin. The level can be written whole, or changed pin by pin through a set register and a clear register. Each pin level is brought into the controller clock domain through a synchroniser, and software can read the result.

Any pin can be armed to watch for rising edges, falling edges or both. A detected edge latches a status bit, and software clears that bit by writing 1 to it. The status bits are split into two halves of 16. Each half drives its own interrupt line, and that line is gated by a per-bank enable bit. An interrupt controller outside the block takes the two lines.

The bus has a byte address, a write strobe, write data and read data. A write takes effect at the clock edge where the strobe is high. Read data is combinational from the address.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset the direction word reads 0xFFFFFFFF, so every pin is an input and pin_oe is 0. Output data, both edge-enable words, the status word and the bank-enable word all read 0. Both bank_irq lines are low.
- R2: The direction word at byte offset 0x10 is read/write. Bit n set to 1 makes pin n an input; set to 0 it makes pin n an output. pin_oe[n] is the inverse of direction bit n from the cycle after the write.
- R3: The output word at 0x14 is read/write and drives pin_out. A write to 0x18 sets every output bit written as 1. A write to 0x1C clears every output bit written as 1. Bits written as 0 are unchanged. Reading 0x18 or 0x1C returns the output word.
- R4: Reading 0x20 returns the pin levels after a two-flop synchroniser, output pins included. A pin change applied before clock edge k reads back after edge k+1.
- R5: The rising-edge enables are set by writing 1s to 0x24 and cleared by writing 1s to 0x28. Either offset reads back the current enables. An enabled pin that goes from 0 to 1 sets its status bit one clock after the change is visible at 0x20.
- R6: The falling-edge enables are set through 0x2C and cleared through 0x30, and either offset reads back the current enables. A pin armed for both edges flags on either transition.
- R7: The status word at 0x34 is write-one-to-clear. A bit written as 0 keeps its value, and an edge on a pin with no enabled edge type sets nothing.
- R8: The bank-enable word at 0x08 is read/write, with bit 0 for bank 0 and bit 1 for bank 1. bank_irq[0] is high while any status bit 15:0 is set and bit 0 is set. bank_irq[1] does the same for status bits 31:16 and bit 1.
- R9: If a new enabled edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R10: Offsets 0x00, 0x04, 0x0C, any offset from 0x38 up, and any address with bits 1:0 non-zero read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output levels to the pads |
| pin_oe | output | 32 | Output enables to the pads |
| bank_irq | output | 2 | Interrupt line of each 16-pin bank |

## Verification
The bench pushes a status clear into the exact cycle in which a new edge on the same pin lands. A design that let the clear win would lose that interrupt. It reads the input word one and two cycles after a pin change. A synchroniser that was one stage too short or too long would show up as an early or late value. It arms pins for single and double edges and then disarms some of them. A mix-up of the rising and falling enables, or of the set and clear registers, would flag the wrong transitions. Bank 1 is left pending while its enable is off, so a line that ignored the enable, or was wired to the wrong half, would assert.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    localparam int NPIN  = 32;
    localparam int NBANK = 2;

    // word indices (byte offset / 4)
    localparam int W_BEN   = 2;
    localparam int W_DIR   = 4;
    localparam int W_OUT   = 5;
    localparam int W_SET   = 6;
    localparam int W_CLR   = 7;
    localparam int W_IN    = 8;
    localparam int W_SRISE = 9;
    localparam int W_CRISE = 10;
    localparam int W_SFALL = 11;
    localparam int W_CFALL = 12;
    localparam int W_STAT  = 13;

    typedef struct packed {
        logic [NPIN-1:0]  dir;
        logic [NPIN-1:0]  dout;
        logic [NPIN-1:0]  rise_en;
        logic [NPIN-1:0]  fall_en;
        logic [NBANK-1:0] ben;
    } cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] prev
);
    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[s] <= '0;
                end else if (s == 0) begin
                    stg_q[s] <= din;
                end else begin
                    stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stg_q[STAGES-1];
    end

    assign lvl  = stg_q[STAGES-1];
    assign prev = prev_q;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
    parameter int NPIN  = 32,
    parameter int NBANK = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIN-1:0]  lvl,
    input  logic [NPIN-1:0]  prev,
    input  logic [NPIN-1:0]  rise_en,
    input  logic [NPIN-1:0]  fall_en,
    input  logic [NPIN-1:0]  clr_mask,
    input  logic [NBANK-1:0] ben,
    output logic [NPIN-1:0]  stat,
    output logic [NBANK-1:0] irq
);
    localparam int BW = NPIN / NBANK;

    logic [NPIN-1:0] stat_d, stat_q, hit;

    always_comb begin
        hit    = (lvl & ~prev & rise_en) | (~lvl & prev & fall_en);
        stat_d = (stat_q & ~clr_mask) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            assign irq[b] = ben[b] & (|stat_q[b*BW +: BW]);
        end
    endgenerate

    assign stat = stat_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_edge_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [NPIN-1:0]   wdata,
    input  logic [NPIN-1:0]   sync_lvl,
    input  logic [NPIN-1:0]   stat,
    output cfg_t              cfg,
    output logic [NPIN-1:0]   stat_clr,
    output logic [NPIN-1:0]   rdata
);
    localparam int WA_W = ADDR_W - 2;

    cfg_t            cfg_d, cfg_q;
    logic [WA_W-1:0] word;
    logic            aligned;

    assign word    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        cfg_d    = cfg_q;
        stat_clr = '0;
        if (we && aligned) begin
            case (int'(word))
                W_BEN:   cfg_d.ben     = wdata[NBANK-1:0];
                W_DIR:   cfg_d.dir     = wdata;
                W_OUT:   cfg_d.dout    = wdata;
                W_SET:   cfg_d.dout    = cfg_q.dout | wdata;
                W_CLR:   cfg_d.dout    = cfg_q.dout & ~wdata;
                W_SRISE: cfg_d.rise_en = cfg_q.rise_en | wdata;
                W_CRISE: cfg_d.rise_en = cfg_q.rise_en & ~wdata;
                W_SFALL: cfg_d.fall_en = cfg_q.fall_en | wdata;
                W_CFALL: cfg_d.fall_en = cfg_q.fall_en & ~wdata;
                W_STAT:  stat_clr      = wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            case (int'(word))
                W_BEN:            rdata[NBANK-1:0] = cfg_q.ben;
                W_DIR:            rdata = cfg_q.dir;
                W_OUT, W_SET, W_CLR: rdata = cfg_q.dout;
                W_IN:             rdata = sync_lvl;
                W_SRISE, W_CRISE: rdata = cfg_q.rise_en;
                W_SFALL, W_CFALL: rdata = cfg_q.fall_en;
                W_STAT:           rdata = stat;
                default:          rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.dir     <= '1;
            cfg_q.dout    <= '0;
            cfg_q.rise_en <= '0;
            cfg_q.fall_en <= '0;
            cfg_q.ben     <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NBANK-1:0]  bank_irq
);
    cfg_t            cfg_w;
    logic [NPIN-1:0] lvl_w, prev_w, stat_w, clr_w;
    logic [NBANK-1:0] ben_w;

    gpio_sync #(.WIDTH(NPIN), .STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .lvl(lvl_w), .prev(prev_w)
    );

    gpio_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .sync_lvl(lvl_w), .stat(stat_w),
        .cfg(cfg_w), .stat_clr(clr_w), .rdata(bus_rdata)
    );

    gpio_edge #(.NPIN(NPIN), .NBANK(NBANK)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_w), .prev(prev_w),
        .rise_en(cfg_w.rise_en), .fall_en(cfg_w.fall_en), .clr_mask(clr_w),
        .ben(cfg_w.ben), .stat(stat_w), .irq(bank_irq)
    );

    assign ben_w   = cfg_w.ben;
    assign pin_out = cfg_w.dout;
    assign pin_oe  = ~cfg_w.dir;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       pin_out,
    input logic [31:0]       pin_oe,
    input logic [1:0]        bank_irq,
    input logic [31:0]       stat,
    input logic [1:0]        ben
);
    logic wr_dir, wr_set, wr_clr, wr_stat;
    assign wr_dir  = bus_we && bus_addr == 8'h10;
    assign wr_set  = bus_we && bus_addr == 8'h18;
    assign wr_clr  = bus_we && bus_addr == 8'h1C;
    assign wr_stat = bus_we && bus_addr == 8'h34;

    p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> pin_oe == ~$past(bus_wdata));

    p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> (pin_out & $past(bus_wdata)) == $past(bus_wdata));

    p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (pin_out & $past(bus_wdata)) == 32'h0);

    p_stat_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> (($past(stat) & ~stat) == 32'h0));

    p_bank0_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ben[0] |-> !bank_irq[0]);

    p_bank1_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ben[1] |-> !bank_irq[1]);
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .bank_irq(bank_irq), .stat(stat_w), .ben(ben_w)
);

// File: tb/gpio_edge_ctrl_bench.sv
module gpio_edge_ctrl_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  bus_addr = 0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = 0;
    logic [31:0] pin_out, pin_oe;
    logic [1:0]  bank_irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    gpio_edge_ctrl u_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq)
    );

    // reference state
    logic [31:0] m_dir = '1, m_out = 0, m_rise = 0, m_fall = 0, m_stat = 0;
    logic [1:0]  m_ben = 0;
    logic [31:0] hist [$] = '{32'h0, 32'h0, 32'h0, 32'h0};

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a[1:0] != 0) return 0;
        case (a)
            8'h08: return {30'h0, m_ben};
            8'h10: return m_dir;
            8'h14, 8'h18, 8'h1C: return m_out;
            8'h20: return hist[1];
            8'h24, 8'h28: return m_rise;
            8'h2C, 8'h30: return m_fall;
            8'h34: return m_stat;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "rdata", bus_rdata, m_read(bus_addr));
        chk("R3", "pin_out", pin_out, m_out);
        chk("R2", "pin_oe", pin_oe, ~m_dir);
        chk("R8", "bank_irq", {30'h0, bank_irq},
            {30'h0, m_ben[1] & (|m_stat[31:16]), m_ben[0] & (|m_stat[15:0])});
    endtask

    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] wd,
                        input logic [31:0] pins, input string tag);
        logic [31:0] hits, clr;
        bus_we = we; bus_addr = a; bus_wdata = wd; pin_in = pins;
        @(posedge clk);
        hits = (hist[1] & ~hist[2] & m_rise) | (~hist[1] & hist[2] & m_fall);
        clr  = 0;
        if (we && a[1:0] == 0) begin
            case (a)
                8'h08: m_ben = wd[1:0];
                8'h10: m_dir = wd;
                8'h14: m_out = wd;
                8'h18: m_out = m_out | wd;
                8'h1C: m_out = m_out & ~wd;
                8'h24: m_rise = m_rise | wd;
                8'h28: m_rise = m_rise & ~wd;
                8'h2C: m_fall = m_fall | wd;
                8'h30: m_fall = m_fall & ~wd;
                8'h34: clr = wd;
                default: ;
            endcase
        end
        m_stat = (m_stat & ~clr) | hits;
        hist.push_front(pins);
        void'(hist.pop_back());
        @(negedge clk);
        compare(tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(0, a, 0, pin_in, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(1, a, d, pin_in, tag);
    endtask

    task automatic pins(input logic [31:0] p, input logic [7:0] a, input string tag);
        step(0, a, 0, p, tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare("R1");
        // R1 reset values
        rd(8'h10, "R1"); rd(8'h14, "R1"); rd(8'h24, "R1"); rd(8'h2C, "R1");
        rd(8'h34, "R1"); rd(8'h08, "R1");
        // R10 unmapped reads and writes
        rd(8'h00, "R10"); rd(8'h3C, "R10"); rd(8'h11, "R10");
        wr(8'h00, 32'hFFFF_FFFF, "R10"); wr(8'h0C, 32'hFFFF_FFFF, "R10");
        wr(8'h12, 32'h0, "R10"); wr(8'h40, 32'h1234, "R10");
        rd(8'h10, "R10"); rd(8'h14, "R10");
        // R2 direction
        wr(8'h10, 32'hFFFF_0000, "R2"); rd(8'h10, "R2");
        wr(8'h10, 32'h0F0F_F0F0, "R2"); rd(8'h10, "R2");
        // R3 output data, set, clear
        wr(8'h14, 32'h1234_5678, "R3");
        wr(8'h18, 32'h0000_000F, "R3"); rd(8'h18, "R3");
        wr(8'h1C, 32'h0000_0030, "R3"); rd(8'h1C, "R3");
        wr(8'h18, 32'h0, "R3"); wr(8'h1C, 32'h0, "R3"); rd(8'h14, "R3");
        // R4 synchronised input, visible two edges later
        pins(32'hA5A5_0000, 8'h20, "R4");
        rd(8'h20, "R4"); rd(8'h20, "R4");
        pins(32'h0000_5A5A, 8'h20, "R4"); rd(8'h20, "R4"); rd(8'h20, "R4");
        // R5 / R6 arming
        wr(8'h24, 32'h0000_0101, "R5"); rd(8'h28, "R5");
        wr(8'h2C, 32'h0001_0100, "R6"); rd(8'h30, "R6");
        wr(8'h08, 32'h3, "R8"); rd(8'h08, "R8");
        pins(32'h0, 8'h34, "R6");
        for (int i = 0; i < 3; i++) rd(8'h34, "R6");
        pins(32'h0001_0101, 8'h34, "R5");
        for (int i = 0; i < 3; i++) rd(8'h34, "R5");
        pins(32'h0, 8'h34, "R6");
        for (int i = 0; i < 3; i++) rd(8'h34, "R6");
        // R7 write-zero no effect, then clear per bit
        wr(8'h34, 32'h0, "R7"); rd(8'h34, "R7");
        wr(8'h34, 32'h0000_0100, "R7"); rd(8'h34, "R7");
        wr(8'h34, 32'hFFFF_FFFF, "R7"); rd(8'h34, "R7");
        // unarmed pin toggles set nothing
        pins(32'h8000_0002, 8'h34, "R7");
        for (int i = 0; i < 3; i++) rd(8'h34, "R7");
        // disarm rising on bit 0
        wr(8'h28, 32'h0000_0001, "R5");
        pins(32'h0000_0101, 8'h34, "R5");
        for (int i = 0; i < 3; i++) rd(8'h34, "R5");
        wr(8'h34, 32'hFFFF_FFFF, "R7");
        // R9 edge and clear in same cycle
        pins(32'h0000_0000, 8'h34, "R9");   // falling on bit 8 (armed both)
        rd(8'h34, "R9");
        wr(8'h34, 32'h0000_0100, "R9");     // coincides with edge landing
        rd(8'h34, "R9");
        // R8 bank 1 pending with enable off
        wr(8'h08, 32'h1, "R8");
        pins(32'h0001_0000, 8'h34, "R8");
        pins(32'h0000_0000, 8'h34, "R8");
        for (int i = 0; i < 3; i++) rd(8'h34, "R8");
        wr(8'h08, 32'h2, "R8"); rd(8'h34, "R8");
        wr(8'h34, 32'hFFFF_0000, "R8"); rd(8'h34, "R8");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule